// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns a bank of protection entries into plain inclusive byte ranges. Each entry has an 8-bit configuration byte and an address register that holds a physical address shifted right by two. The block looks at the two matching-mode bits of each configuration byte and works out a low and a high byte address for that entry. A permission checker downstream then compares an access against these ranges. The block also reports how many entries are switched on.

The decoder is purely combinational. The number of entries and the width of the address register are parameters. The byte addresses are two bits wider than the address registers, so that shifting left by two never loses a bit. A top-of-range entry takes its lower bound from the entry just below it. When that lower bound lies above the entry's own upper bound, the entry collapses to an empty range of 0..0.

Top module: `prb_bounds_decoder`

## Requirements
- R1: The matching mode of an entry is taken from configuration bits [4:3] only: 0 = disabled, 1 = top-of-range, 2 = aligned 4-byte, 3 = aligned power-of-two. All other configuration bits have no effect on any output.
- R2: A disabled entry reports low bound 0 and high bound all-ones across the full byte-address width.
- R3: A top-of-range entry takes its low bound from the previous entry's address register with two zero bits appended. Entry 0 uses a previous address of zero.
- R4: A top-of-range entry's high bound is its own address with two zero bits appended, minus one, modulo the byte-address width. An own address of zero therefore gives all-ones.
- R5: If a top-of-range low bound is greater than its high bound, both bounds are reported as 0. This includes equal, nonzero previous and own addresses.
- R6: An aligned 4-byte entry reports low bound = address with two zero bits appended, and high bound = low bound + 3.
- R7: An aligned power-of-two entry with k trailing ones in its address covers 2^(k+3) bytes. The low bound is the address with two zero bits appended, with its lowest k+3 bits cleared. The high bound is the low bound with those bits set. When k+3 reaches the byte-address width, the result is 0 to all-ones.
- R8: The active count equals the number of entries whose mode field is not 0.
- R9: Outputs follow the inputs combinationally, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_i | input | N_ENTRIES*8 | Configuration bytes; entry i sits at bits [8i+7:8i] |
| addr_i | input | N_ENTRIES*XLEN | Address registers (byte address >> 2); entry i at [XLEN*i +: XLEN] |
| lo_o | output | N_ENTRIES*(XLEN+2) | Inclusive low byte bound per entry |
| hi_o | output | N_ENTRIES*(XLEN+2) | Inclusive high byte bound per entry |
| active_cnt_o | output | $clog2(N_ENTRIES+1) | Number of entries whose mode is not disabled |

## Verification
Every result is due zero cycles after its stimulus, because no register sits between the inputs and the outputs. This holds even when an entry's bounds depend on its neighbour's address. Each scenario task drives the whole configuration and address bank, waits a short settling delay well away from any bench clock edge, and then compares every affected bound and the count with values worked out from the requirements. The power-of-two check counts trailing ones rather than using the carry formula. Because an entry's bounds depend on the entry below it, those cases change the neighbour's address and check the dependent entry again.

// File: rtl/prb_pkg.sv
package prb_pkg;

    localparam int CFG_W    = 8;
    localparam int MODE_LSB = 3;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    function automatic match_mode_e mode_of(input logic [CFG_W-1:0] cfg);
        return match_mode_e'(cfg[MODE_LSB +: 2]);
    endfunction

endpackage

// File: rtl/prb_tor_range.sv
module prb_tor_range #(
    parameter int XLEN = 32,
    localparam int BW  = XLEN + 2
) (
    input  logic [XLEN-1:0] prev_addr_i,
    input  logic [XLEN-1:0] own_addr_i,
    output logic [BW-1:0]   lo_o,
    output logic [BW-1:0]   hi_o
);

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
    } span_t;

    span_t span_d;

    always_comb begin
        span_d.lo = {prev_addr_i, 2'b00};
        span_d.hi = {own_addr_i, 2'b00} - BW'(1);
        if (span_d.lo > span_d.hi) begin
            span_d.lo = '0;
            span_d.hi = '0;
        end
    end

    assign lo_o = span_d.lo;
    assign hi_o = span_d.hi;

endmodule

// File: rtl/prb_napot_range.sv
module prb_napot_range #(
    parameter int XLEN = 32,
    localparam int BW  = XLEN + 2
) (
    input  logic [XLEN-1:0] addr_i,
    output logic [BW-1:0]   lo_o,
    output logic [BW-1:0]   hi_o
);

    typedef struct packed {
        logic [BW-1:0] ones;
        logic [BW-1:0] inc;
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
    } napot_t;

    napot_t nap_d;

    always_comb begin
        nap_d.ones = {addr_i, 2'b11};
        nap_d.inc  = nap_d.ones + BW'(1);
        nap_d.lo   = nap_d.ones & nap_d.inc;
        nap_d.hi   = nap_d.ones | nap_d.inc;
    end

    assign lo_o = nap_d.lo;
    assign hi_o = nap_d.hi;

endmodule

// File: rtl/prb_entry_decode.sv
module prb_entry_decode
    import prb_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int BW  = XLEN + 2
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [XLEN-1:0]  prev_addr_i,
    input  logic [XLEN-1:0]  addr_i,
    output logic [BW-1:0]    lo_o,
    output logic [BW-1:0]    hi_o,
    output logic             active_o
);

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
        logic          active;
    } bounds_t;

    logic [BW-1:0] tor_lo, tor_hi, nap_lo, nap_hi;
    match_mode_e   mode;
    bounds_t       bounds_d;
    logic          unused_cfg_bits;

    assign mode            = mode_of(cfg_i);
    assign unused_cfg_bits = ^{cfg_i[CFG_W-1:MODE_LSB+2], cfg_i[MODE_LSB-1:0]};

    prb_tor_range #(.XLEN(XLEN)) u_tor (
        .prev_addr_i (prev_addr_i),
        .own_addr_i  (addr_i),
        .lo_o        (tor_lo),
        .hi_o        (tor_hi)
    );

    prb_napot_range #(.XLEN(XLEN)) u_napot (
        .addr_i (addr_i),
        .lo_o   (nap_lo),
        .hi_o   (nap_hi)
    );

    always_comb begin
        bounds_d.active = (mode != MATCH_OFF);
        unique case (mode)
            MATCH_TOR: begin
                bounds_d.lo = tor_lo;
                bounds_d.hi = tor_hi;
            end
            MATCH_NA4: begin
                bounds_d.lo = {addr_i, 2'b00};
                bounds_d.hi = {addr_i, 2'b11};
            end
            MATCH_NAPOT: begin
                bounds_d.lo = nap_lo;
                bounds_d.hi = nap_hi;
            end
            default: begin
                bounds_d.lo = '0;
                bounds_d.hi = '1;
            end
        endcase
    end

    assign lo_o     = bounds_d.lo;
    assign hi_o     = bounds_d.hi;
    assign active_o = bounds_d.active;

endmodule

// File: rtl/prb_active_count.sv
module prb_active_count #(
    parameter int N_ENTRIES = 8,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
    input  logic [N_ENTRIES-1:0] active_i,
    output logic [CNT_W-1:0]     count_o
);

    logic [CNT_W-1:0] count_d;

    always_comb begin
        count_d = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            count_d = count_d + CNT_W'(active_i[i]);
        end
    end

    assign count_o = count_d;

endmodule

// File: rtl/prb_bounds_decoder.sv
module prb_bounds_decoder
    import prb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int XLEN      = 32,
    localparam int BW       = XLEN + 2,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
    input  logic [N_ENTRIES*CFG_W-1:0] cfg_i,
    input  logic [N_ENTRIES*XLEN-1:0]  addr_i,
    output logic [N_ENTRIES*BW-1:0]    lo_o,
    output logic [N_ENTRIES*BW-1:0]    hi_o,
    output logic [CNT_W-1:0]           active_cnt_o
);

    logic [N_ENTRIES-1:0] active_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        logic [XLEN-1:0] prev_addr;
        if (g == 0) begin : g_first
            assign prev_addr = '0;
        end else begin : g_rest
            assign prev_addr = addr_i[(g-1)*XLEN +: XLEN];
        end

        prb_entry_decode #(.XLEN(XLEN)) u_dec (
            .cfg_i       (cfg_i[g*CFG_W +: CFG_W]),
            .prev_addr_i (prev_addr),
            .addr_i      (addr_i[g*XLEN +: XLEN]),
            .lo_o        (lo_o[g*BW +: BW]),
            .hi_o        (hi_o[g*BW +: BW]),
            .active_o    (active_q[g])
        );
    end

    prb_active_count #(.N_ENTRIES(N_ENTRIES)) u_cnt (
        .active_i (active_q),
        .count_o  (active_cnt_o)
    );

endmodule

// File: rtl/prb_bounds_checker.sv
module prb_bounds_checker
    import prb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int XLEN      = 32,
    localparam int BW       = XLEN + 2,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
    input logic [N_ENTRIES*CFG_W-1:0] cfg_i,
    input logic [N_ENTRIES*XLEN-1:0]  addr_i,
    input logic [N_ENTRIES*BW-1:0]    lo_o,
    input logic [N_ENTRIES*BW-1:0]    hi_o,
    input logic [CNT_W-1:0]           active_cnt_o
);

    logic unused_addr;
    assign unused_addr = ^addr_i;

    always_comb begin
        int unsigned on_cnt;
        on_cnt = 0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            logic [BW-1:0] lo, hi, span;
            logic [1:0]    md;
            lo   = lo_o[i*BW +: BW];
            hi   = hi_o[i*BW +: BW];
            span = hi - lo;
            md   = cfg_i[i*CFG_W + MODE_LSB +: 2];
            if (md != 2'd0) on_cnt++;
            AST_ORDERED: assert (lo <= hi);                                       // R5
            AST_OFF_FULL: assert (md != 2'd0 || (lo == '0 && hi == '1));          // R2
            AST_NA4_SPAN: assert (md != 2'd2 || span == BW'(3));                  // R6
            AST_NAPOT_ALIGN: assert (md != 2'd3 ||
                ((((span + BW'(1)) & span) == '0) && ((lo & span) == '0)));       // R7
        end
        AST_COUNT_MATCH: assert (active_cnt_o == CNT_W'(on_cnt));                 // R8
    end

endmodule

bind prb_bounds_decoder prb_bounds_checker #(
    .N_ENTRIES (N_ENTRIES),
    .XLEN      (XLEN)
) u_prb_chk (
    .cfg_i        (cfg_i),
    .addr_i       (addr_i),
    .lo_o         (lo_o),
    .hi_o         (hi_o),
    .active_cnt_o (active_cnt_o)
);

// File: tb/prb_bounds_decoder_tb.sv
module prb_bounds_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int XL         = 32;
    localparam int BW         = XL + 2;
    localparam int CW         = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]    cfg_a  [N];
    logic [XL-1:0] addr_a [N];
    logic [N*8-1:0]  cfg_i;
    logic [N*XL-1:0] addr_i;
    logic [N*BW-1:0] lo_o, hi_o;
    logic [CW-1:0]   active_cnt_o;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg_i[i*8 +: 8]   = cfg_a[i];
            addr_i[i*XL +: XL] = addr_a[i];
        end
    end

    prb_bounds_decoder #(.N_ENTRIES(N), .XLEN(XL)) dut_i (
        .cfg_i        (cfg_i),
        .addr_i       (addr_i),
        .lo_o         (lo_o),
        .hi_o         (hi_o),
        .active_cnt_o (active_cnt_o)
    );

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            cfg_a[i]  = 8'h00;
            addr_a[i] = '0;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic chk_entry(input int idx, input logic [BW-1:0] elo,
                             input logic [BW-1:0] ehi, input string req);
        logic [BW-1:0] alo, ahi;
        alo = lo_o[idx*BW +: BW];
        ahi = hi_o[idx*BW +: BW];
        n_vec++;
        if (alo !== elo || ahi !== ehi) begin
            n_miss++;
            $display("FAIL %s entry %0d: got lo=%h hi=%h expected lo=%h hi=%h",
                     req, idx, alo, ahi, elo, ehi);
        end
    endtask

    task automatic chk_count(input int exp, input string req);
        n_vec++;
        if (int'(active_cnt_o) != exp) begin
            n_miss++;
            $display("FAIL %s count: got %0d expected %0d", req, active_cnt_o, exp);
        end
    endtask

    function automatic logic [BW-1:0] sh(input logic [XL-1:0] a);
        return {a, 2'b00};
    endfunction

    task automatic napot_exp(input logic [XL-1:0] a,
                             output logic [BW-1:0] s, output logic [BW-1:0] e);
        int k;
        logic [BW-1:0] mask;
        k = 0;
        while (k < XL && a[k]) k++;
        if (k + 3 >= BW) begin
            s = '0;
            e = '1;
        end else begin
            mask = (BW'(1) << (k + 3)) - BW'(1);
            s = sh(a) & ~mask;
            e = s | mask;
        end
    endtask

    // R2, R8: everything disabled after reset
    task automatic t_reset_state();
        clear_all();
        settle();
        for (int i = 0; i < N; i++) chk_entry(i, '0, '1, "R2");
        chk_count(0, "R8");
    endtask

    // R3, R4: top-of-range chaining
    task automatic t_tor_basic();
        clear_all();
        cfg_a[0] = 8'h08; addr_a[0] = 32'h100;
        cfg_a[1] = 8'h08; addr_a[1] = 32'h200;
        settle();
        chk_entry(0, '0, BW'('h3FF), "R3");
        chk_entry(1, BW'('h400), BW'('h7FF), "R4");
        addr_a[0] = 32'h180;
        settle();
        chk_entry(1, BW'('h600), BW'('h7FF), "R3");
        cfg_a[2] = 8'h08; addr_a[2] = 32'h0; addr_a[1] = 32'h0;
        settle();
        chk_entry(2, '0, '1, "R4");
        chk_count(3, "R8");
    endtask

    // R5: inverted and equal top-of-range collapse
    task automatic t_tor_empty();
        clear_all();
        addr_a[1] = 32'h200;
        cfg_a[2] = 8'h08; addr_a[2] = 32'h80;
        cfg_a[4] = 8'h08; addr_a[3] = 32'h55; addr_a[4] = 32'h55;
        settle();
        chk_entry(2, '0, '0, "R5");
        chk_entry(4, '0, '0, "R5");
        addr_a[1] = 32'h7F;
        settle();
        chk_entry(2, BW'('h1FC), BW'('h1FF), "R5");
    endtask

    // R6: aligned four bytes
    task automatic t_na4();
        clear_all();
        cfg_a[3] = 8'h10; addr_a[3] = 32'h1234;
        cfg_a[7] = 8'h10; addr_a[7] = 32'hFFFF_FFFF;
        settle();
        chk_entry(3, BW'('h48D0), BW'('h48D3), "R6");
        chk_entry(7, sh(32'hFFFF_FFFF), '1, "R6");
    endtask

    // R7: power-of-two regions of several sizes
    task automatic t_napot();
        logic [XL-1:0] pats [5] = '{32'h1000, 32'h1003, 32'h2000_0FFF,
                                    32'h7FFF_FFFF, 32'hFFFF_FFFF};
        logic [BW-1:0] s, e;
        clear_all();
        for (int i = 0; i < 5; i++) begin
            cfg_a[i] = 8'h18; addr_a[i] = pats[i];
        end
        settle();
        for (int i = 0; i < 5; i++) begin
            napot_exp(pats[i], s, e);
            chk_entry(i, s, e, "R7");
        end
        chk_count(5, "R8");
    endtask

    // R1, R9: non-mode bits ignored, outputs follow instantly
    task automatic t_ignored_bits();
        clear_all();
        cfg_a[0] = 8'hE7; addr_a[0] = 32'h40;
        cfg_a[1] = 8'h8F; addr_a[1] = 32'h80;
        cfg_a[2] = 8'h75; addr_a[2] = 32'h10;
        settle();
        chk_entry(0, '0, '1, "R1");
        chk_entry(1, BW'('h100), BW'('h1FF), "R1");
        chk_entry(2, BW'('h40), BW'('h43), "R1");
        chk_count(2, "R1");
        #1;
        cfg_a[0] = 8'h10;
        #1;
        chk_entry(0, BW'('h100), BW'('h103), "R9");
    endtask

    // R8: full bank active, then mixed
    task automatic t_count();
        clear_all();
        for (int i = 0; i < N; i++) cfg_a[i] = 8'h18;
        settle();
        chk_count(N, "R8");
        cfg_a[2] = 8'h00; cfg_a[5] = 8'h07;
        settle();
        chk_count(N - 2, "R8");
    endtask

    initial begin
        clear_all();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_tor_basic();
        t_tor_empty();
        t_na4();
        t_napot();
        t_ignored_bits();
        t_count();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule